// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial-side front end of a small byte-addressed memory of up to 512 bytes. It runs on a system clock. Its chip-select, serial-clock, serial-in and pause pins are assumed to be synchronized already. It finds serial-clock edges in those pins and shifts instruction, address and data bits in on rising edges, most significant bit first. It decodes the instruction byte, which also carries address bit 8. On falling edges it shifts read data or a status byte out on a serial-out line that has its own enable.

The block does not commit writes and does not check write enable or protection. It reports each decoded command as a one-cycle strobe with a command code and a start address. Each received write byte is reported as a one-cycle data strobe. During reads the block drives a byte address to the array and takes the byte back on `rd_data`. The address pointer advances after each byte and wraps to zero past the top. A pause input can freeze a transfer mid-byte and later resume it. Serial clock modes 0 and 3 both work.

The controller FSM has these states:
- `ST_OPCODE`: collecting the opcode.
- `ST_ADDR`: collecting the address byte.
- `ST_RDATA`: streaming array data.
- `ST_SRDATA`: streaming the status byte.
- `ST_WDATA`: collecting write data.
- `ST_WSTAT`: collecting the new status byte.
- `ST_SKIP`: ignoring everything until deselect.

Its transitions are:
- OPCODE→ADDR on a read or write opcode.
- OPCODE→SRDATA on a status read.
- OPCODE→WSTAT on a status write.
- OPCODE→SKIP on enable-set, enable-clear or an unknown opcode.
- ADDR→RDATA or ADDR→WDATA when the address byte completes.
- WSTAT→SKIP after one byte.
- Any state→OPCODE while chip select is high.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, and while chip select is high, `so_oe` is 0 and no `cmd_stb` or `data_stb` pulse appears.
- R2: Bits are taken from `si` on `sck` rising edges, most significant bit first. An opcode with upper nibble 0 and low three bits 110 gives `cmd_stb` with `cmd_op`=4 (enable set). Low bits 100 give `cmd_op`=3 (enable clear).
- R3: An opcode with upper nibble 0 and low bits 011, followed by an address byte, gives `cmd_stb` with `cmd_op`=1 and `cmd_addr` = {opcode bit 3, address byte}. The array byte at that address then appears on `so_data`, most significant bit first, with each bit changing after an `sck` falling edge.
- R4: During a read, each further byte comes from the next address, and the address after 511 is 0.
- R5: Low bits 010 with an address byte give `cmd_stb` with `cmd_op`=2 and the address built as in R3. Each further complete byte gives one `data_stb` with that byte on `data_byte`, and `so_oe` stays 0.
- R6: Low bits 101 give `cmd_op`=5 and stream `status_in` repeatedly on `so_data`. Low bits 001 give `cmd_op`=6, and the next byte gives one `data_stb`.
- R7: For opcodes that take no address, bit 3 is a don't-care.
- R8: Raising chip select turns `so_oe` off, ends a read and discards a partly received byte. The next selection starts with a fresh opcode.
- R9: An opcode with a nonzero upper nibble, or with low bits 000 or 111, gives no strobe. Later bytes are ignored until deselect, and `so_oe` stays 0.
- R10: Pulling `hold_n` low while `sck` is low pauses the transfer: `so_oe` goes to 0 and `sck`/`si` activity is ignored. Raising `hold_n` while `sck` is low resumes at the same bit.
- R11: Pulling `hold_n` low while `sck` is high keeps the output driving until the next `sck` falling edge. That edge is still honoured, and the pause begins after it.
- R12: Transfers work both with `sck` idling low (mode 0) and idling high (mode 3) at chip-select fall. In mode 3 the first falling edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low (synchronized) |
| sck | input | 1 | Serial clock (synchronized) |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (0 = high impedance) |
| cmd_stb | output | 1 | One-cycle decoded command strobe |
| cmd_op | output | 3 | Command code: 1 read, 2 write, 3 enable clear, 4 enable set, 5 status read, 6 status write |
| cmd_addr | output | ADDR_W | Start address for read/write commands |
| data_stb | output | 1 | One-cycle strobe per received write/status byte |
| data_byte | output | 8 | Received byte |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array byte at `rd_addr` |
| status_in | input | 8 | Status byte to send on a status read |

## Verification
Several properties are checked on every cycle:
- The controller returns to opcode collection after deselect.
- While paused, neither the state nor the read pointer moves.
- The read pointer only holds or steps by one.
- A pause begins only while the serial clock is low.
- No command strobe carries the null code.
- The skip state never drives the output.

Other behaviours are shown only by the bench's scenarios: the bit order of streamed data, the decoded addresses including bit 8, wrap from 511 to 0, resumption at the exact paused bit, and correct framing after an aborted partial byte in both clock modes.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_WRDIS = 3'd3,
        OP_WREN  = 3'd4,
        OP_RDST  = 3'd5,
        OP_WRST  = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_SRDATA,
        ST_WDATA,
        ST_WSTAT,
        ST_SKIP
    } st_e;

    // Upper nibble must be zero; bit 3 is address bit 8 or don't-care.
    function automatic op_e decode_op(input logic [7:0] b);
        op_e r;
        r = OP_NONE;
        if (b[7:4] == 4'h0) begin
            case (b[2:0])
                3'b011:  r = OP_READ;
                3'b010:  r = OP_WRITE;
                3'b100:  r = OP_WRDIS;
                3'b110:  r = OP_WREN;
                3'b101:  r = OP_RDST;
                3'b001:  r = OP_WRST;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_pin_ctl.sv
module spi_pin_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic rise,
    output logic fall,
    output logic held
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            held  <= 1'b0;
        end else begin
            sck_q <= sck;
            if (cs_n)
                held <= 1'b0;
            else if (!held && !hold_n && !sck)
                held <= 1'b1;
            else if (held && hold_n && !sck)
                held <= 1'b0;
        end
    end

    assign rise = !cs_n && !held &&  sck && !sck_q;
    assign fall = !cs_n && !held && !sck &&  sck_q;

    AST_PAUSE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> !sck);                          // R11
    AST_RESUME_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(held) && !cs_n) |-> (hold_n && !sck));   // R10

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         si,
    output logic         byte_stb,
    output logic [W-1:0] byte_val
);
    localparam int CW = $clog2(W);

    logic [W-2:0] sr;
    logic [CW-1:0] cnt;

    assign byte_stb = shift && (cnt == CW'(W - 1));
    assign byte_val = {sr, si};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (shift) begin
            sr  <= {sr[W-3:0], si};
            cnt <= cnt + 1'b1;
        end
    end

    AST_RX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));                           // R8

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] byte_in,
    output logic         so_bit,
    output logic         need,
    output logic         live
);
    localparam int CW = $clog2(W);

    logic [W-2:0] sr;
    logic [CW-1:0] cnt;

    assign need = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr     <= '0;
            cnt    <= '0;
            so_bit <= 1'b0;
            live   <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            live <= 1'b0;
        end else if (step) begin
            live <= 1'b1;
            if (cnt == '0) begin
                so_bit <= byte_in[W-1];
                sr     <= byte_in[W-2:0];
                cnt    <= CW'(W - 1);
            end else begin
                so_bit <= sr[W-2];
                sr     <= {sr[W-3:0], 1'b0};
                cnt    <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so_data,
    output logic              so_oe,
    output logic              cmd_stb,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              data_stb,
    output logic [7:0]        data_byte,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic [7:0]        status_in
);
    localparam int BW    = 8;
    localparam int FULLW = BW + 1;

    st_e st_q, st_d;
    op_e op_q, cmd_op_q, dec;

    logic rise, fall, held;
    logic byte_stb;
    logic [BW-1:0] byte_val;
    logic tx_step, tx_clr, tx_need, tx_live, tx_bit;
    logic streaming;
    logic a8_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [FULLW-1:0] full_addr;

    spi_pin_ctl u_pins (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .rise(rise), .fall(fall), .held(held)
    );

    spi_rx_shift #(.W(BW)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(cs_n), .shift(rise), .si(si),
        .byte_stb(byte_stb), .byte_val(byte_val)
    );

    assign streaming = (st_q == ST_RDATA) || (st_q == ST_SRDATA);
    assign tx_step   = fall && streaming;
    assign tx_clr    = cs_n || !streaming;

    spi_tx_shift #(.W(BW)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .step(tx_step),
        .byte_in((st_q == ST_RDATA) ? rd_data : status_in),
        .so_bit(tx_bit), .need(tx_need), .live(tx_live)
    );

    assign dec       = decode_op(byte_val);
    assign full_addr = {a8_q, byte_val};

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = ST_OPCODE;
        end else if (byte_stb) begin
            unique case (st_q)
                ST_OPCODE: begin
                    case (dec)
                        OP_READ, OP_WRITE: st_d = ST_ADDR;
                        OP_RDST:           st_d = ST_SRDATA;
                        OP_WRST:           st_d = ST_WSTAT;
                        default:           st_d = ST_SKIP;
                    endcase
                end
                ST_ADDR:   st_d = (op_q == OP_READ) ? ST_RDATA : ST_WDATA;
                ST_WSTAT:  st_d = ST_SKIP;
                ST_RDATA, ST_SRDATA, ST_WDATA, ST_SKIP: st_d = st_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OPCODE;
        else        st_q <= st_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_NONE;
            a8_q      <= 1'b0;
            ptr_q     <= '0;
            cmd_stb   <= 1'b0;
            cmd_op_q  <= OP_NONE;
            cmd_addr  <= '0;
            data_stb  <= 1'b0;
            data_byte <= '0;
        end else begin
            cmd_stb  <= 1'b0;
            data_stb <= 1'b0;
            if (byte_stb && st_q == ST_OPCODE) begin
                op_q <= dec;
                a8_q <= byte_val[3];
                if (dec inside {OP_WRDIS, OP_WREN, OP_RDST, OP_WRST}) begin
                    cmd_stb  <= 1'b1;
                    cmd_op_q <= dec;
                    cmd_addr <= '0;
                end
            end
            if (byte_stb && st_q == ST_ADDR) begin
                cmd_stb  <= 1'b1;
                cmd_op_q <= op_q;
                cmd_addr <= full_addr[ADDR_W-1:0];
                ptr_q    <= full_addr[ADDR_W-1:0];
            end
            if (byte_stb && (st_q == ST_WDATA || st_q == ST_WSTAT)) begin
                data_stb  <= 1'b1;
                data_byte <= byte_val;
            end
            if (tx_step && tx_need && st_q == ST_RDATA)
                ptr_q <= ptr_q + 1'b1;
        end
    end

    assign cmd_op  = cmd_op_q;
    assign rd_addr = ptr_q;
    assign so_data = tx_bit;
    assign so_oe   = !cs_n && !held && streaming && tx_live;

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> (st_q == ST_OPCODE));                      // R8
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_n) |=> ($stable(ptr_q) && $stable(st_q)));    // R10
    AST_CMD_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (cmd_op_q != OP_NONE));                        // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RDATA && $past(st_q) == ST_RDATA) |->
        (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1));   // R4
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SKIP) |-> !so_oe);                             // R9

endmodule

// File: tb/sim_spi_mem_front.sv
`timescale 1ns/1ps
module sim_spi_mem_front;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so_data, so_oe, cmd_stb, data_stb;
    logic [2:0] cmd_op;
    logic [8:0] cmd_addr, rd_addr;
    logic [7:0] data_byte, rd_data;
    logic [7:0] status_in = 8'hA5;

    int nchk = 0, nerr = 0;
    int ncmd = 0, ndata = 0;
    logic [2:0] last_op = '0;
    logic [8:0] last_addr = '0;
    logic [7:0] last_data = '0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] memval(input int a);
        return 8'(((a * 37) + 5) ^ (a >> 3));
    endfunction

    assign rd_data = memval(int'(rd_addr));

    spi_mem_front #(.ADDR_W(9)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so_data(so_data), .so_oe(so_oe), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .data_stb(data_stb), .data_byte(data_byte),
        .rd_addr(rd_addr), .rd_data(rd_data), .status_in(status_in)
    );

    always @(posedge clk) begin
        if (cmd_stb) begin ncmd++; last_op = cmd_op; last_addr = cmd_addr; end
        if (data_stb) begin ndata++; last_data = data_byte; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic sob, output logic oeb);
        sck = 1'b0; si = b; tick(4);
        sob = so_data; oeb = so_oe;
        sck = 1'b1; tick(4);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
        logic sb, ob;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_io(tx[i], sb, ob);
            rx[i] = sb; oe_any |= ob;
        end
    endtask

    task automatic sel(input logic mode3);
        sck = mode3; tick(3); cs_n = 1'b0; tick(3);
    endtask

    task automatic desel(input logic mode3);
        sck = mode3; tick(4); cs_n = 1'b1; tick(4);
    endtask

    // kind: 0 none, 1 pause with SCK low, 2 pause requested with SCK high
    task automatic rd_byte_hold(input int kind, input int at, output logic [7:0] rx);
        logic sb, ob;
        for (int k = 0; k < 8; k++) begin
            bit_io(1'b0, sb, ob);
            rx[7-k] = sb;
            if (k == at && kind == 1) begin
                sck = 1'b0; tick(4);
                hold_n = 1'b0; tick(3);
                chk("R10 so_oe off while paused", so_oe, 0);
                for (int t = 0; t < 3; t++) begin
                    sck = 1'b1; si = 1'b1; tick(4);
                    sck = 1'b0; si = 1'b0; tick(4);
                end
                hold_n = 1'b1; tick(4);
                chk("R10 so_oe back after resume", so_oe, 1);
            end
            if (k == at && kind == 2) begin
                hold_n = 1'b0; tick(4);
                chk("R11 still driving while SCK high", so_oe, 1);
                sck = 1'b0; tick(4);
                chk("R11 paused after SCK fall", so_oe, 0);
                sck = 1'b1; tick(4);
                sck = 1'b0; tick(4);
                hold_n = 1'b1; tick(4);
                chk("R11 so_oe back after resume", so_oe, 1);
            end
        end
    endtask

    // {opcode, address byte, expected 9-bit address}
    localparam logic [24:0] RD_VEC [4] = '{
        {8'h03, 8'h10, 9'h010},
        {8'h0B, 8'h20, 9'h120},
        {8'h03, 8'hFF, 9'h0FF},
        {8'h0B, 8'hFF, 9'h1FF}
    };

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] rx;
        logic oe;
        int c0, d0;

        tick(4); rst_n = 1'b1; tick(4);
        chk("R1 so_oe after reset", so_oe, 0);
        chk("R1 no command after reset", ncmd, 0);

        // Table walk: reads, alternating mode 0 / mode 3 (R3, R4, R12)
        for (int v = 0; v < 4; v++) begin
            logic m3;
            int a;
            m3 = (v % 2) == 1;
            a  = int'(RD_VEC[v][8:0]);
            c0 = ncmd;
            sel(m3);
            xbyte(RD_VEC[v][24:17], rx, oe);
            xbyte(RD_VEC[v][16:9], rx, oe);
            for (int k = 0; k < 3; k++) begin
                xbyte(8'h00, rx, oe);
                chk(m3 ? "R12 mode3 read data" : "R3 read data", rx, memval((a + k) % 512));
            end
            desel(m3);
            chk("R3 read strobe count", ncmd - c0, 1);
            chk("R3 read cmd_op", last_op, 1);
            chk("R4 read start address", last_addr, a);
        end

        // R2 enable set, R7 enable clear with bit 3 set
        sel(0); xbyte(8'h06, rx, oe); desel(0);
        chk("R2 enable-set cmd_op", last_op, 4);
        sel(0); xbyte(8'h0C, rx, oe); desel(0);
        chk("R7 bit3 don't-care enable-clear", last_op, 3);

        // R5 write
        d0 = ndata;
        sel(0);
        xbyte(8'h0A, rx, oe); xbyte(8'h34, rx, oe);
        xbyte(8'h11, rx, oe); xbyte(8'h22, rx, oe);
        desel(0);
        chk("R5 write cmd_op", last_op, 2);
        chk("R5 write address", last_addr, 9'h134);
        chk("R5 data strobes", ndata - d0, 2);
        chk("R5 last data byte", last_data, 8'h22);
        chk("R5 no output during write", oe, 0);

        // R6 status read and status write
        sel(1);
        xbyte(8'h05, rx, oe);
        xbyte(8'h00, rx, oe); chk("R6 status byte 1", rx, 8'hA5);
        status_in = 8'h3C;
        xbyte(8'h00, rx, oe); chk("R6 status byte 2", rx, 8'h3C);
        desel(1);
        chk("R6 status read cmd_op", last_op, 5);
        d0 = ndata;
        sel(0); xbyte(8'h01, rx, oe); xbyte(8'h9C, rx, oe); xbyte(8'h77, rx, oe); desel(0);
        chk("R6 status write cmd_op", last_op, 6);
        chk("R6 one status data strobe", ndata - d0, 1);
        chk("R6 status data byte", last_data, 8'h9C);

        // R9 unknown opcodes
        c0 = ncmd; d0 = ndata;
        sel(0); xbyte(8'h43, rx, oe); xbyte(8'h03, rx, oe); xbyte(8'h10, rx, oe); xbyte(8'h00, rx, oe);
        chk("R9 no output for unknown opcode", oe, 0);
        desel(0);
        sel(0); xbyte(8'h07, rx, oe); xbyte(8'h06, rx, oe); desel(0);
        chk("R9 no strobes for unknown opcodes", (ncmd - c0) + (ndata - d0), 0);

        // R8 aborted partial byte, then a clean opcode
        sel(0);
        for (int i = 0; i < 4; i++) begin logic sb, ob; bit_io(1'b1, sb, ob); end
        desel(0);
        sel(0); xbyte(8'h06, rx, oe); desel(0);
        chk("R8 fresh opcode after abort", last_op, 4);

        // R10 / R11 pauses inside a read
        sel(0);
        xbyte(8'h03, rx, oe); xbyte(8'h40, rx, oe);
        rd_byte_hold(1, 2, rx); chk("R10 paused byte intact", rx, memval(9'h40));
        rd_byte_hold(0, 0, rx); chk("R10 next byte after pause", rx, memval(9'h41));
        rd_byte_hold(2, 4, rx); chk("R11 late pause byte intact", rx, memval(9'h42));
        sck = 1'b0; tick(4);
        cs_n = 1'b1; tick(2);
        chk("R8 so_oe off on deselect", so_oe, 0);
        tick(4);
        chk("R1 so_oe idle while deselected", so_oe, 0);

        report();
    end

endmodule